// File: doc/BRIEF.md
# Fixed-Point DSP Arithmetic Logic Unit

This block is the 16-bit arithmetic logic unit of a fixed-point signal-processing datapath. Each cycle it takes an X operand, a Y operand, a carry input, an operation code and a condition flag. When the condition flag is high, it computes the selected operation and stores the result in one of two destination registers: the primary result register or the feedback register. In the same edge it updates four status flags: zero, negative, carry and overflow. When the condition flag is low, the operation is dropped, and the registers and flags keep their values.

The operation set has the following groups:

- add, with and without carry;
- subtract in both operand orders (X−Y and Y−X), each with an optional borrow form that adds C−1;
- AND, OR and XOR;
- pass, negate, NOT and absolute value, all on X;
- increment and decrement, both on Y;
- a clear operation.

Results and flags are registered and appear one clock edge after the operands are presented.

Top module: `dsp_alu_core`

## Requirements
- R1: While `rst` is high at a rising edge, `res_q`, `fb_q` and all four flags become 0.
- R2: Code 0 gives X+Y and code 1 gives X+Y+C. `flag_c` is the unsigned carry out of bit 15. `flag_v` is the two's-complement signed overflow.
- R3: Code 2 gives X−Y and code 3 gives X−Y+C−1. `flag_c` is the adder carry-out (1 means no borrow) and `flag_v` is signed overflow.
- R4: Code 4 gives Y−X and code 5 gives Y−X+C−1, with carry and overflow defined as in R3.
- R5: Code 6 gives X AND Y, code 7 gives X OR Y, code 8 gives X XOR Y and code 11 gives NOT X. All four clear `flag_c` and `flag_v`.
- R6: The X-only operations and clear behave as follows:
  - Code 9 passes X, and code 15 clears the result to 0; both clear C and V.
  - Code 10 gives 0−X, with carry-out and overflow as in R3.
  - Code 12 gives |X| with C cleared. |0x8000| is 0x8000 with V set.
- R7: Code 13 gives Y+1 and code 14 gives Y−1 (computed as Y+0xFFFF). Both set carry-out and overflow as in R2.
- R8: With `cond_ok` high, `dest_fb`=0 writes `res_q` and leaves `fb_q` unchanged, and `dest_fb`=1 writes `fb_q` and leaves `res_q` unchanged.
- R9: With `cond_ok` low, `res_q`, `fb_q` and all flags hold their values whatever the other inputs are.
- R10: On every executed operation, `flag_z` is set exactly when the 16-bit result is 0, and `flag_n` equals bit 15 of the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand |
| c_in | input | 1 | Carry flag used by the carry and borrow forms |
| cond_ok | input | 1 | The operation executes only when this is high |
| op | input | 4 | Operation code (see R2–R7) |
| dest_fb | input | 1 | 0 selects the result register, 1 selects the feedback register |
| res_q | output | 16 | Primary result register |
| fb_q | output | 16 | Feedback register |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Two events share a single edge: the flag update and the write to the chosen destination register. The flags must follow the new result whichever register receives it, and the other register must stay untouched. The bench provokes this by sending an overflowing subtract to the feedback register right after a result-register write. It then checks both registers and all four flags against its own arithmetic model. It also changes the operands and the operation while the condition is false, and judges that nothing at the outputs moved.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBB  = 4'd3,
    OP_RSUB  = 4'd4,
    OP_RSUBB = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_PASS  = 4'd9,
    OP_NEG   = 4'd10,
    OP_NOT   = 4'd11,
    OP_ABS   = 4'd12,
    OP_INC   = 4'd13,
    OP_DEC   = 4'd14,
    OP_CLR   = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         c,
  output logic [W-1:0] a,
  output logic [W-1:0] b,
  output logic         cin,
  output logic         use_adder
);
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] NIL  = '0;

  always_comb begin
    a = x;
    b = y;
    cin = 1'b0;
    use_adder = 1'b1;
    unique case (op)
      OP_ADD:   begin a = x;   b = y;  cin = 1'b0; end
      OP_ADDC:  begin a = x;   b = y;  cin = c;    end
      OP_SUB:   begin a = x;   b = ~y; cin = 1'b1; end
      OP_SUBB:  begin a = x;   b = ~y; cin = c;    end
      OP_RSUB:  begin a = y;   b = ~x; cin = 1'b1; end
      OP_RSUBB: begin a = y;   b = ~x; cin = c;    end
      OP_NEG:   begin a = NIL; b = ~x; cin = 1'b1; end
      OP_INC:   begin a = y;   b = NIL;  cin = 1'b1; end
      OP_DEC:   begin a = y;   b = ONES; cin = 1'b0; end
      default:  use_adder = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int MSB = W - 1;
  logic [W:0] full;

  assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign sum  = full[W-1:0];
  assign cout = full[W];
  assign ovf  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] mag;
  assign mag = x[MSB] ? (~x + 1'b1) : x;

  always_comb begin
    ovf = 1'b0;
    unique case (op)
      OP_AND:  res = x & y;
      OP_OR:   res = x | y;
      OP_XOR:  res = x ^ y;
      OP_NOT:  res = ~x;
      OP_PASS: res = x;
      OP_ABS:  begin res = mag; ovf = (x == MIN_NEG); end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/dsp_alu_core.sv
module dsp_alu_core
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         c_in,
  input  logic         cond_ok,
  input  logic [3:0]   op,
  input  logic         dest_fb,
  output logic [W-1:0] res_q,
  output logic [W-1:0] fb_q,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_c,
  output logic         flag_v
);
  localparam int NDEST = 2;
  localparam int MSB   = W - 1;

  alu_op_e      op_e;
  logic [W-1:0] add_a, add_b, add_sum, lu_res, result;
  logic         add_cin, add_cout, add_ovf, lu_ovf, use_adder;
  logic         next_c, next_v;
  logic [W-1:0] dst_q [NDEST];

  assign op_e = alu_op_e'(op);

  alu_operand_sel #(.W(W)) u_sel (
    .op(op_e), .x(x_in), .y(y_in), .c(c_in),
    .a(add_a), .b(add_b), .cin(add_cin), .use_adder(use_adder)
  );

  alu_adder #(.W(W)) u_add (
    .a(add_a), .b(add_b), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  alu_logic_unit #(.W(W)) u_lu (
    .op(op_e), .x(x_in), .y(y_in), .res(lu_res), .ovf(lu_ovf)
  );

  always_comb begin
    if (use_adder) begin
      result = add_sum;
      next_c = add_cout;
      next_v = add_ovf;
    end else begin
      result = lu_res;
      next_c = 1'b0;
      next_v = lu_ovf;
    end
  end

  for (genvar g = 0; g < NDEST; g++) begin : g_dest
    always_ff @(posedge clk) begin
      if (rst)
        dst_q[g] <= '0;
      else if (cond_ok && (int'(dest_fb) == g))
        dst_q[g] <= result;
    end
  end

  assign res_q = dst_q[0];
  assign fb_q  = dst_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end else if (cond_ok) begin
      flag_z <= (result == '0);
      flag_n <= result[MSB];
      flag_c <= next_c;
      flag_v <= next_v;
    end
  end
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] x_in,
  input logic [W-1:0] y_in,
  input logic         c_in,
  input logic         cond_ok,
  input logic [3:0]   op,
  input logic         dest_fb,
  input logic [W-1:0] res_q,
  input logic [W-1:0] fb_q,
  input logic         flag_z,
  input logic         flag_n,
  input logic         flag_c,
  input logic         flag_v
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (res_q == '0 && fb_q == '0 && !flag_z && !flag_n && !flag_c && !flag_v));

  a_r9_hold_when_false: assert property (@(posedge clk) disable iff (rst)
    !cond_ok |=> ($stable(res_q) && $stable(fb_q) && $stable(flag_z)
                  && $stable(flag_n) && $stable(flag_c) && $stable(flag_v)));

  a_r8_fb_keeps_res: assert property (@(posedge clk) disable iff (rst)
    (cond_ok && dest_fb) |=> $stable(res_q));

  a_r8_res_keeps_fb: assert property (@(posedge clk) disable iff (rst)
    (cond_ok && !dest_fb) |=> $stable(fb_q));

  a_r5_logic_clears_cv: assert property (@(posedge clk) disable iff (rst)
    (cond_ok && (op == 4'd6 || op == 4'd7 || op == 4'd8 || op == 4'd11))
      |=> (!flag_c && !flag_v));

  a_r2_addc_sum: assert property (@(posedge clk) disable iff (rst)
    (cond_ok && op == 4'd1 && !dest_fb)
      |=> res_q == W'($past(x_in) + $past(y_in) + W'($past(c_in))));

  a_r6_abs_min: assert property (@(posedge clk) disable iff (rst)
    (cond_ok && op == 4'd12 && x_in == MIN_NEG && !dest_fb)
      |=> (res_q == MIN_NEG && flag_v && !flag_c));

  a_r10_zero_neg: assert property (@(posedge clk) disable iff (rst)
    cond_ok |=> (($past(dest_fb) ? (fb_q == '0) : (res_q == '0)) == flag_z)
             && (($past(dest_fb) ? fb_q[W-1] : res_q[W-1]) == flag_n));
endmodule

bind dsp_alu_core alu_checker #(.W(W)) u_alu_checker (.*);

// File: tb/test_dsp_alu_core.sv
module test_dsp_alu_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] x_in = '0, y_in = '0;
  logic        c_in = 1'b0, cond_ok = 1'b0, dest_fb = 1'b0;
  logic [3:0]  op = '0;
  logic [15:0] res_q, fb_q;
  logic        flag_z, flag_n, flag_c, flag_v;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] e_res = '0, e_fb = '0;
  logic        e_z = 0, e_n = 0, e_c = 0, e_v = 0;

  always #2 clk = ~clk;

  dsp_alu_core i_dsp_alu_core (.*);

  task automatic compare(input string tag);
    logic [35:0] got, exp;
    got = {res_q, fb_q, flag_z, flag_n, flag_c, flag_v};
    exp = {e_res, e_fb, e_z, e_n, e_c, e_v};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual res=%h fb=%h znCV=%b expected res=%h fb=%h znCV=%b",
               tag, got[35:20], got[19:4], got[3:0], exp[35:20], exp[19:4], exp[3:0]);
    end
  endtask

  // Independent arithmetic model of the requirements.
  task automatic model(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                       input logic c, output logic [15:0] r, output logic cf, output logic vf);
    int ux = x, uy = y, sx = $signed(x), sy = $signed(y), ci = c;
    int u = 0, s = 0;
    bit arith = 1;
    case (o)
      4'd0:  begin u = ux + uy;              s = sx + sy; end
      4'd1:  begin u = ux + uy + ci;         s = sx + sy + ci; end
      4'd2:  begin u = ux + (65535-uy) + 1;  s = sx - sy; end
      4'd3:  begin u = ux + (65535-uy) + ci; s = sx - sy + ci - 1; end
      4'd4:  begin u = uy + (65535-ux) + 1;  s = sy - sx; end
      4'd5:  begin u = uy + (65535-ux) + ci; s = sy - sx + ci - 1; end
      4'd10: begin u = (65535-ux) + 1;       s = -sx; end
      4'd13: begin u = uy + 1;               s = sy + 1; end
      4'd14: begin u = uy + 65535;           s = sy - 1; end
      default: arith = 0;
    endcase
    if (arith) begin
      r = u[15:0]; cf = u[16]; vf = (s > 32767) || (s < -32768);
    end else begin
      cf = 0; vf = 0;
      case (o)
        4'd6:  r = x & y;
        4'd7:  r = x | y;
        4'd8:  r = x ^ y;
        4'd11: r = ~x;
        4'd9:  r = x;
        4'd12: begin s = (sx < 0) ? -sx : sx; r = s[15:0]; vf = (x == 16'h8000); end
        default: r = 16'h0000;
      endcase
    end
  endtask

  task automatic exec(input string tag, input logic [3:0] o, input logic [15:0] x,
                      input logic [15:0] y, input logic c, input logic d);
    logic [15:0] r; logic cf, vf;
    @(negedge clk);
    op = o; x_in = x; y_in = y; c_in = c; dest_fb = d; cond_ok = 1'b1;
    @(negedge clk);
    cond_ok = 1'b0;
    model(o, x, y, c, r, cf, vf);
    if (d) e_fb = r; else e_res = r;
    e_z = (r == 16'h0); e_n = r[15]; e_c = cf; e_v = vf;
    compare(tag);
  endtask

  task automatic t_reset;
    compare("R1 reset state");
  endtask

  task automatic t_add;
    exec("R2 add plain", 4'd0, 16'h1234, 16'h0101, 1'b0, 1'b0);
    exec("R2 add carry-out", 4'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b0);
    exec("R2 add signed overflow", 4'd0, 16'h7FFF, 16'h0001, 1'b0, 1'b0);
    exec("R2 add with carry", 4'd1, 16'h0010, 16'h0020, 1'b1, 1'b0);
  endtask

  task automatic t_sub;
    exec("R3 sub borrow", 4'd2, 16'h0003, 16'h0005, 1'b0, 1'b0);
    exec("R3 sub equal zero", 4'd2, 16'h4444, 16'h4444, 1'b0, 1'b0);
    exec("R3 subb c=0", 4'd3, 16'h0005, 16'h0003, 1'b0, 1'b0);
    exec("R3 subb c=1 overflow", 4'd3, 16'h8000, 16'h0001, 1'b1, 1'b0);
  endtask

  task automatic t_rsub;
    exec("R4 rsub", 4'd4, 16'h0002, 16'h0009, 1'b0, 1'b0);
    exec("R4 rsubb c=0", 4'd5, 16'h0009, 16'h0002, 1'b0, 1'b0);
    exec("R4 rsubb c=1", 4'd5, 16'h0001, 16'h8000, 1'b1, 1'b0);
  endtask

  task automatic t_logic;
    exec("R5 add sets carry first", 4'd0, 16'hFFFF, 16'h8000, 1'b0, 1'b0);
    exec("R5 and", 4'd6, 16'hF0F0, 16'hFF00, 1'b0, 1'b0);
    exec("R5 or", 4'd7, 16'h0F00, 16'h00F0, 1'b1, 1'b0);
    exec("R5 xor zero", 4'd8, 16'hA5A5, 16'hA5A5, 1'b0, 1'b0);
    exec("R5 not", 4'd11, 16'h00FF, 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic t_xops;
    exec("R6 pass", 4'd9, 16'h8001, 16'h1111, 1'b1, 1'b0);
    exec("R6 negate zero", 4'd10, 16'h0000, 16'h0000, 1'b0, 1'b0);
    exec("R6 negate min", 4'd10, 16'h8000, 16'h0000, 1'b0, 1'b0);
    exec("R6 abs negative", 4'd12, 16'hFFF6, 16'h0000, 1'b0, 1'b0);
    exec("R6 abs min overflow", 4'd12, 16'h8000, 16'h0000, 1'b0, 1'b0);
    exec("R6 clear", 4'd15, 16'h1234, 16'h5678, 1'b1, 1'b0);
  endtask

  task automatic t_incdec;
    exec("R7 inc wrap", 4'd13, 16'h1234, 16'hFFFF, 1'b0, 1'b0);
    exec("R7 inc overflow", 4'd13, 16'h0000, 16'h7FFF, 1'b0, 1'b0);
    exec("R7 dec zero", 4'd14, 16'h5555, 16'h0000, 1'b0, 1'b0);
    exec("R7 dec one", 4'd14, 16'h0000, 16'h0001, 1'b0, 1'b0);
  endtask

  task automatic t_dest;
    exec("R8 write result reg", 4'd0, 16'h0100, 16'h0023, 1'b0, 1'b0);
    exec("R8 R10 overflowing sub into feedback", 4'd2, 16'h8000, 16'h0001, 1'b0, 1'b1);
    exec("R8 feedback again", 4'd13, 16'h0000, 16'h00FE, 1'b0, 1'b1);
  endtask

  task automatic t_cond;
    @(negedge clk);
    op = 4'd15; x_in = 16'hDEAD; y_in = 16'hBEEF; c_in = 1'b1; dest_fb = 1'b0; cond_ok = 1'b0;
    @(negedge clk);
    compare("R9 suppressed clear to result");
    dest_fb = 1'b1; op = 4'd2;
    @(negedge clk);
    compare("R9 suppressed sub to feedback");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_add();
    t_sub();
    t_rsub();
    t_logic();
    t_xops();
    t_incdec();
    t_dest();
    t_cond();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule